// File: doc/BRIEF.md
# Quad I/O Fast-Read Sequencer

This block is the flash-side slave logic that serves quad-I/O fast reads on a four-wire data bus. While chip select is low it watches the serial clock, takes in an eight-bit opcode one bit per rising edge on IO0, then a 24-bit address and an 8-bit mode field at four bits per rising edge. It waits a fixed number of dummy clocks and then streams bytes from an attached memory, one nibble per falling edge. It fetches each byte through a synchronous byte-read port and steps the address after each byte.

Two opcodes are served. The plain quad read uses four dummy clocks. The word variant uses two dummy clocks and aligns the start address to an even byte. A mode field whose upper nibble is 0xA arms continuous mode. In that mode the next transaction skips the opcode and begins directly with the address, using the variant that armed it. A separate one-cycle pulse disarms it. The block samples the serial clock, chip select and data pins with its own system clock. The serial clock idles low.

Top module: `quad_read_seq`

## Requirements
- R1: After reset, and from the system clock cycle after chip select is seen high, all four output enables are 0 and no memory read is issued.
- R2: Opcode 0xEB with quad enable set is served as follows. Eight opcode bits arrive MSB first on IO0, one per rising edge. Six address nibbles follow, with bit 3 of each nibble (IO3) the more significant, so the first nibble is A23..A20. Two mode nibbles come next, M7..M4 first, then four dummy rising edges. From the falling edge after the last dummy rising edge, each falling edge drives one nibble on IO3..IO0 with all four enables at 1: the high nibble of a byte first, then its low nibble.
- R3: Opcode 0xE7 takes two dummy rising edges instead of four and forces address bit 0 to 0 before the first fetch.
- R4: The address steps by one after every byte sent and wraps from 0xFFFFFF to 0x000000.
- R5: With quad enable at 0, opcodes 0xEB and 0xE7 are ignored. The outputs are never enabled and no memory read occurs until chip select is raised.
- R6: Any other opcode is ignored in the same way.
- R7: A mode field with upper nibble 0xA makes the next transaction start directly with the address nibbles, with no opcode, and keep the dummy count and alignment of the opcode that armed it.
- R8: A mode field with any other upper nibble makes the next transaction expect an opcode again.
- R9: A one-cycle pulse on modeClear disarms continuous mode, so the next transaction expects an opcode.
- R10: Raising chip select at any bit ends the transaction and resets the bit and phase counters. A later transaction starts cleanly, and the continuous-mode state is kept.
- R11: memRdEn is a single-cycle pulse, one per byte. The addressed byte must be on memRdData from the cycle after the pulse until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock from the host, idle low |
| csN | input | 1 | Active-low chip select |
| ioIn | input | 4 | Input values of IO3..IO0 |
| ioOut | output | 4 | Output values for IO3..IO0 |
| ioOe | output | 4 | Output enables for IO3..IO0 (1 = drive) |
| quadEnable | input | 1 | Quad enable status bit; quad opcodes are accepted only when 1 |
| modeClear | input | 1 | One-cycle pulse that disarms continuous mode |
| memAddr | output | 24 | Byte address of the current memory read |
| memRdEn | output | 1 | One-cycle memory read strobe |
| memRdData | input | 8 | Byte returned by the memory, valid from the cycle after memRdEn |

## Verification
The assertions assume the following about the host:
- Each serial clock phase lasts at least four system clocks.
- At least one system clock passes between the fall of chip select and the first rising serial edge.
- The memory holds its output byte between reads.

The bench drives every serial phase for exactly four system clocks. It opens and closes chip select with the serial clock low and one half-period of margin. Its memory model registers a computed byte on each read strobe and holds it until the next strobe.

// File: rtl/quad_read_pkg.sv
package quad_read_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_MODE,
    ST_DUMMY,
    ST_DATA,
    ST_SKIP
  } seqState_t;

  typedef struct packed {
    logic clear;      // chip select high: drop outputs
    logic shiftCmd;   // take IO0 into the opcode shifter
    logic shiftAddr;  // take a nibble into the address shifter
    logic shiftMode;  // take a mode nibble
    logic startRead;  // issue the first fetch
    logic forceEven;  // word variant: clear address bit 0
    logic launch;     // falling edge in data phase: drive next nibble
  } seqStrobe_t;

endpackage

// File: rtl/quad_read_ctrl.sv
module quad_read_ctrl
  import quad_read_pkg::*;
#(
  parameter logic [7:0] OPC_QUAD   = 8'hEB,
  parameter logic [7:0] OPC_WORD   = 8'hE7,
  parameter int         DUMMY_QUAD = 4,
  parameter int         DUMMY_WORD = 2,
  parameter int         ADDR_W     = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclk,
  input  logic       csN,
  input  logic       quadEnable,
  input  logic       modeClear,
  input  logic [7:0] cmdNext,
  input  logic [3:0] modeUpper,
  output seqStrobe_t strobe
);
  localparam int ADDR_NIB = ADDR_W / 4;
  localparam int CNT_MAX  = (ADDR_NIB > 8) ? ADDR_NIB : 8;
  localparam int CNT_W    = $clog2(CNT_MAX);

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             sclkQ;
  logic             wordMode;
  logic             contFlag;
  logic             rise;
  logic             fall;
  logic [CNT_W-1:0] dummyLast;
  logic             isQuadOpc;

  assign rise      = ~csN & sclk & ~sclkQ;
  assign fall      = ~csN & ~sclk & sclkQ;
  assign dummyLast = wordMode ? CNT_W'(DUMMY_WORD - 1) : CNT_W'(DUMMY_QUAD - 1);
  assign isQuadOpc = (cmdNext == OPC_QUAD) || (cmdNext == OPC_WORD);

  always_comb begin
    strobe           = '0;
    strobe.clear     = csN;
    strobe.shiftCmd  = rise && (state == ST_CMD);
    strobe.shiftAddr = rise && (state == ST_ADDR);
    strobe.shiftMode = rise && (state == ST_MODE);
    strobe.startRead = rise && (state == ST_DUMMY) && (cnt == dummyLast);
    strobe.forceEven = wordMode;
    strobe.launch    = fall && (state == ST_DATA);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      sclkQ    <= 1'b0;
      wordMode <= 1'b0;
      contFlag <= 1'b0;
    end else begin
      sclkQ <= sclk;
      if (csN) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            state <= contFlag ? ST_ADDR : ST_CMD;
            cnt   <= '0;
          end
          ST_CMD: if (rise) begin
            if (cnt == CNT_W'(7)) begin
              cnt <= '0;
              if (isQuadOpc && quadEnable) begin
                state    <= ST_ADDR;
                wordMode <= (cmdNext == OPC_WORD);
              end else begin
                state <= ST_SKIP;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_ADDR: if (rise) begin
            if (cnt == CNT_W'(ADDR_NIB - 1)) begin
              state <= ST_MODE;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_MODE: if (rise) begin
            if (cnt == CNT_W'(1)) begin
              contFlag <= (modeUpper == 4'hA);
              state    <= ST_DUMMY;
              cnt      <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DUMMY: if (rise) begin
            if (cnt == dummyLast) begin
              state <= ST_DATA;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (modeClear) contFlag <= 1'b0;
    end
  end

  AST_QE_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CMD && rise && cnt == CNT_W'(7) && !quadEnable) |=> (state == ST_SKIP)); // R5
  AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    modeClear |=> !contFlag); // R9
  AST_CS_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (state == ST_IDLE && cnt == '0)); // R10

endmodule

// File: rtl/quad_read_dp.sv
module quad_read_dp
  import quad_read_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        ioIn,
  input  seqStrobe_t        strobe,
  output logic [7:0]        cmdNext,
  output logic [3:0]        modeUpper,
  output logic [3:0]        ioOut,
  output logic [3:0]        ioOe,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  input  logic [7:0]        memRdData
);
  logic [6:0]        cmdReg;
  logic [ADDR_W-1:0] addrReg;
  logic [ADDR_W-1:0] startAddr;
  logic [3:0]        modeNib;
  logic [3:0]        hold;
  logic [3:0]        outReg;
  logic              nibbleSel;
  logic              oeReg;
  logic [ADDR_W-1:0] memAddrReg;
  logic              rdEnReg;

  assign cmdNext   = {cmdReg, ioIn[0]};
  assign modeUpper = modeNib;
  assign startAddr = strobe.forceEven ? {addrReg[ADDR_W-1:1], 1'b0} : addrReg;
  assign ioOut     = outReg;
  assign ioOe      = {4{oeReg}};
  assign memAddr   = memAddrReg;
  assign memRdEn   = rdEnReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg     <= '0;
      addrReg    <= '0;
      modeNib    <= '0;
      hold       <= '0;
      outReg     <= '0;
      nibbleSel  <= 1'b0;
      oeReg      <= 1'b0;
      memAddrReg <= '0;
      rdEnReg    <= 1'b0;
    end else begin
      rdEnReg <= 1'b0;
      if (strobe.clear) begin
        oeReg     <= 1'b0;
        nibbleSel <= 1'b0;
      end
      if (strobe.shiftCmd)  cmdReg  <= cmdNext[6:0];
      if (strobe.shiftAddr) addrReg <= {addrReg[ADDR_W-5:0], ioIn};
      if (strobe.shiftMode) modeNib <= ioIn;
      if (strobe.startRead) begin
        addrReg    <= startAddr;
        memAddrReg <= startAddr;
        rdEnReg    <= 1'b1;
        nibbleSel  <= 1'b0;
      end
      if (strobe.launch) begin
        oeReg     <= 1'b1;
        nibbleSel <= ~nibbleSel;
        if (!nibbleSel) begin
          outReg     <= memRdData[7:4];
          hold       <= memRdData[3:0];
          addrReg    <= addrReg + 1'b1;
          memAddrReg <= addrReg + 1'b1;
          rdEnReg    <= 1'b1;
        end else begin
          outReg <= hold;
        end
      end
    end
  end

  AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn); // R11
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.launch && !nibbleSel) |=> (memAddr == ADDR_W'($past(memAddr) + 1'b1))); // R4
  AST_WORD_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.startRead && strobe.forceEven) |=> !memAddr[0]); // R3
  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (ioOe == 4'h0)); // R1
  AST_OE_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oeReg) |-> $past(strobe.launch)); // R2

endmodule

// File: rtl/quad_read_seq.sv
module quad_read_seq
  import quad_read_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              csN,
  input  logic [3:0]        ioIn,
  output logic [3:0]        ioOut,
  output logic [3:0]        ioOe,
  input  logic              quadEnable,
  input  logic              modeClear,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  input  logic [7:0]        memRdData
);
  seqStrobe_t strobe;
  logic [7:0] cmdNext;
  logic [3:0] modeUpper;

  quad_read_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sclk      (sclk),
    .csN       (csN),
    .quadEnable(quadEnable),
    .modeClear (modeClear),
    .cmdNext   (cmdNext),
    .modeUpper (modeUpper),
    .strobe    (strobe)
  );

  quad_read_dp #(.ADDR_W(ADDR_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ioIn     (ioIn),
    .strobe   (strobe),
    .cmdNext  (cmdNext),
    .modeUpper(modeUpper),
    .ioOut    (ioOut),
    .ioOe     (ioOe),
    .memAddr  (memAddr),
    .memRdEn  (memRdEn),
    .memRdData(memRdData)
  );

endmodule

// File: tb/test_quad_read_seq.sv
module test_quad_read_seq;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;

  logic        clk = 1'b0;
  logic        rstN;
  logic        sclk;
  logic        csN;
  logic [3:0]  ioIn;
  logic [3:0]  ioOut;
  logic [3:0]  ioOe;
  logic        quadEnable;
  logic        modeClear;
  logic [23:0] memAddr;
  logic        memRdEn;
  logic [7:0]  memRdData;

  int compared = 0;
  int mismatched = 0;
  int rdCount = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_read_seq i_quad_read_seq (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .ioIn(ioIn),
    .ioOut(ioOut), .ioOe(ioOe), .quadEnable(quadEnable), .modeClear(modeClear),
    .memAddr(memAddr), .memRdEn(memRdEn), .memRdData(memRdData)
  );

  function automatic logic [7:0] memByte(input logic [23:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ {a[20:16], a[23:21]} ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (memRdEn) begin
      memRdData <= memByte(memAddr);
      rdCount   <= rdCount + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sclkPulse(input logic [3:0] v);
    ioIn = v;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic quadRead(input bit withCmd, input logic [7:0] opc, input bit isWord,
                          input logic [23:0] addr, input logic [7:0] mode,
                          input int nBytes, input bit expectData, input string req);
    logic [23:0] start;
    logic [7:0]  got;
    start = isWord ? {addr[23:1], 1'b0} : addr;
    csN = 1'b0;
    repeat (HALF) @(negedge clk);
    if (withCmd) for (int i = 7; i >= 0; i--) sclkPulse({3'b000, opc[i]});
    for (int n = 5; n >= 0; n--) sclkPulse(addr[n*4 +: 4]);
    sclkPulse(mode[7:4]);
    sclkPulse(mode[3:0]);
    for (int d = 0; d < (isWord ? 2 : 4); d++) sclkPulse(4'h0);
    for (int b = 0; b < nBytes; b++) begin
      for (int h = 0; h < 2; h++) begin
        if (b != 0 || h != 0) sclkPulse(4'h0);
        if (expectData) begin
          check({req, " oe"}, ioOe, 4'hF);
          if (h == 0) got[7:4] = ioOut; else got[3:0] = ioOut;
        end else begin
          check({req, " no drive"}, ioOe, 4'h0);
        end
      end
      if (expectData) check({req, " data"}, got, memByte(24'(start + b)));
    end
    csN = 1'b1;
    repeat (HALF) @(negedge clk);
    check("R1 release", ioOe, 4'h0);
  endtask

  task automatic abortAfter(input logic [7:0] opc, input int nAddr);
    csN = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 7; i >= 0; i--) sclkPulse({3'b000, opc[i]});
    for (int n = 0; n < nAddr; n++) sclkPulse(4'h9);
    csN = 1'b1;
    repeat (HALF) @(negedge clk);
    check("R10 abort release", ioOe, 4'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int rc;
    bit contState;
    bit contWord;
    void'($urandom(32'h1BAD5EED));
    rstN = 1'b0; csN = 1'b1; sclk = 1'b0; ioIn = 4'h0;
    quadEnable = 1'b1; modeClear = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 reset oe", ioOe, 4'h0);
    check("R1 reset rd", rdCount, 0);

    quadRead(1, 8'hEB, 0, 24'h123456, 8'h00, 4, 1, "R2 plain");
    quadRead(1, 8'hE7, 1, 24'h000101, 8'h00, 3, 1, "R3 word odd");
    quadRead(1, 8'hEB, 0, 24'hFFFFFE, 8'h00, 4, 1, "R4 wrap");

    quadEnable = 1'b0;
    rc = rdCount;
    quadRead(1, 8'hEB, 0, 24'h000200, 8'h00, 2, 0, "R5 qe off");
    check("R5 no read", rdCount, rc);
    quadEnable = 1'b1;

    rc = rdCount;
    quadRead(1, 8'h03, 0, 24'h000300, 8'h00, 2, 0, "R6 other opc");
    check("R6 no read", rdCount, rc);

    quadRead(1, 8'hEB, 0, 24'h00ABCD, 8'hA5, 2, 1, "R7 arm");
    quadRead(0, 8'h00, 0, 24'h5A5A00, 8'hA0, 2, 1, "R7 no opcode");
    quadRead(0, 8'h00, 0, 24'h0F0F0F, 8'h5A, 2, 1, "R8 last cont");
    quadRead(1, 8'hEB, 0, 24'h300000, 8'h00, 2, 1, "R8 opcode again");

    quadRead(1, 8'hE7, 1, 24'h000010, 8'hAF, 1, 1, "R7 word arm");
    quadRead(0, 8'h00, 1, 24'h777777, 8'h00, 2, 1, "R7 word cont");
    quadRead(1, 8'hEB, 0, 24'h000040, 8'h00, 1, 1, "R8 after word");

    quadRead(1, 8'hEB, 0, 24'h000050, 8'hA0, 1, 1, "R9 arm");
    modeClear = 1'b1;
    @(negedge clk);
    modeClear = 1'b0;
    quadRead(1, 8'hEB, 0, 24'h000060, 8'h00, 2, 1, "R9 cleared");

    abortAfter(8'hEB, 3);
    quadRead(1, 8'hEB, 0, 24'h004321, 8'h00, 2, 1, "R10 after abort");
    abortAfter(8'hE7, 0);
    quadRead(1, 8'hEB, 0, 24'h00FFFF, 8'h00, 2, 1, "R10 after opc abort");

    rc = rdCount;
    quadRead(1, 8'hEB, 0, 24'h100000, 8'h00, 3, 1, "R11 reads");
    check("R11 one per byte", rdCount - rc, 4);

    contState = 1'b0;
    contWord  = 1'b0;
    for (int k = 0; k < 24; k++) begin
      logic [31:0] r;
      bit          isWord;
      logic [7:0]  mode;
      r = $urandom;
      isWord = contState ? contWord : r[0];
      mode = (r[3:2] == 2'b00) ? {4'hA, r[7:4]} : r[15:8];
      if (mode[7:4] == 4'hA && r[3:2] != 2'b00) mode[7:4] = 4'h3;
      quadRead(!contState, isWord ? 8'hE7 : 8'hEB, isWord, $urandom, mode,
               1 + int'(r[17:16]), 1, contState ? "R7 random cont" : "R2 random");
      if (!contState) contWord = isWord;
      contState = (mode[7:4] == 4'hA);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule